// File: doc/BRIEF.md
# TDM Channel Double Buffer

This block sits between a processor register port and a time-division line that carries two bearer channels, one signalling channel and a spare. Each incoming frame strobe closes one 125 µs frame. Every fourth strobe closes a 500 µs service period. At that period edge every lane moves its stages forward in a single cycle. The byte the processor wrote in the transmit register drops into a transmit shadow, and that shadow drives the line for the whole next period. The byte gathered from the line moves into a receive shadow, and the previous shadow moves into the register the processor reads.

The processor services the block once per period. On each period edge a level interrupt is raised, and it stays high until software acknowledges it. Software then writes each enabled lane's transmit byte and reads each enabled lane's receive byte. At the next edge, any enabled lane that missed either access gets a sticky underrun or overrun bit. Those bits, plus a bit that records an interrupt raised on top of one still pending, drive a second status interrupt. Reading the status registers clears them.

Top module: `tdm_chbuf`

## Requirements
- R1: After reset, every data, enable, flag and control bit is zero. Both interrupts are low, the line output is zero and the slot index is 0.
- R2: Each `frame_strobe` pulse advances `slot_idx` by one, wrapping from 3 to 0. The pulse that arrives while `slot_idx` is 3 is the period edge.
- R3: `irq_period` rises in the cycle after a period edge. It stays high until a write to address 6 with data bit 0 set.
- R4: If a period edge arrives while `irq_period` is still high and no acknowledge is written in that cycle, bit 1 of address 6 is set. Reading address 6 clears that bit. Bit 0 of address 6 reads back the pending state of `irq_period`.
- R5: A byte written to address c (0 to 3) during one period appears on `line_tx_data[8c+7:8c]` from the cycle after that period's edge. It stays unchanged until the following edge. A lane that is not written repeats its last written byte.
- R6: A byte captured from `line_rx_data[8c+7:8c]` while `line_rx_valid[c]` is high becomes readable at address c after the second period edge that follows the capture. When there are several captures in one period, the last one is kept.
- R7: At a period edge, an enabled lane c that was not written since the previous edge sets underrun bit c of address 5 (bits 3..0). An access made in the edge cycle counts toward the period that starts there.
- R8: At a period edge, an enabled lane c whose address was not read since the previous edge sets overrun bit c of address 5 (bits 7..4).
- R9: A lane whose enable bit (address 4, bit c) is 0 at the edge never sets an underrun or overrun bit, whatever accesses it had.
- R10: Underrun and overrun bits stay set across later edges until address 5 is read. That read returns their value and then clears them.
- R11: `irq_status` is high exactly while any underrun, overrun or missed-interrupt bit is set. It can only rise at a period edge.
- R12: `cpu_rdata` presents the addressed register in the cycle after `cpu_rd`. The enable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One-cycle pulse at each frame end |
| slot_idx | output | 2 | Frame position within the period |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| line_tx_data | output | 32 | Transmit bytes of all lanes, lane c at bits 8c+7:8c |
| line_rx_valid | input | 4 | Per-lane receive capture strobe |
| line_rx_data | input | 32 | Receive bytes of all lanes |
| irq_period | output | 1 | Period service interrupt, level |
| irq_status | output | 1 | Error status interrupt, level |

## Verification
Read data is due one cycle after the read strobe. The line bytes, `irq_period`, the flag bits and the slot index are due one cycle after the strobe that makes the edge. A received byte is due after two further edges. The bench drives every input on the falling clock edge and samples on the next falling edge, so each result is read half a period after the register that produces it has loaded. Over sixteen periods the enable mask, write mask and read mask change arithmetically. A lane model in the bench, advanced at every strobe it issues, gives the value each result must have at that point.

// File: rtl/tdm_chbuf_pkg.sv
package tdm_chbuf_pkg;

    // Control register bit positions (address NCH+2)
    localparam int CTRL_PEND_BIT = 0;  // read: period interrupt pending; write 1: acknowledge
    localparam int CTRL_MISS_BIT = 1;  // read: an edge arrived while still pending

    typedef enum logic [1:0] {
        KIND_LANE   = 2'd0,
        KIND_ENABLE = 2'd1,
        KIND_FLAGS  = 2'd2,
        KIND_CTRL   = 2'd3
    } reg_kind_e;

    function automatic reg_kind_e decode_kind(input int addr, input int nch);
        if (addr < nch)           return KIND_LANE;
        else if (addr == nch)     return KIND_ENABLE;
        else if (addr == nch + 1) return KIND_FLAGS;
        else                      return KIND_CTRL;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int SLOTS = 4,
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_strobe,
    output logic [SW-1:0] slot,
    output logic          boundary
);

    typedef struct packed {
        logic [SW-1:0] slot;
    } timer_s;

    timer_s tm_d, tm_q;

    always_comb begin
        tm_d     = tm_q;
        boundary = frame_strobe && (tm_q.slot == SW'(SLOTS - 1));
        if (frame_strobe) begin
            if (boundary) tm_d.slot = '0;
            else          tm_d.slot = tm_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign slot = tm_q.slot;

endmodule

// File: rtl/tdm_chan_lane.sv
module tdm_chan_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          enable,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic [DW-1:0] tx_line,
    output logic [DW-1:0] rx_reg,
    output logic          underrun_set,
    output logic          overrun_set
);

    typedef struct packed {
        logic [DW-1:0] tx_reg;
        logic [DW-1:0] tx_sh;
        logic [DW-1:0] rx_gath;
        logic [DW-1:0] rx_sh;
        logic [DW-1:0] rx_reg;
        logic          written;
        logic          fetched;
    } lane_s;

    lane_s ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        // period edge: advance both pipelines and open a new service window
        if (boundary) begin
            ln_d.tx_sh   = ln_q.tx_reg;
            ln_d.rx_sh   = ln_q.rx_gath;
            ln_d.rx_reg  = ln_q.rx_sh;
            ln_d.written = 1'b0;
            ln_d.fetched = 1'b0;
        end
        // accesses in the edge cycle belong to the new window
        if (wr) begin
            ln_d.tx_reg  = wdata;
            ln_d.written = 1'b1;
        end
        if (rd)       ln_d.fetched = 1'b1;
        if (rx_valid) ln_d.rx_gath = rx_data;

        underrun_set = boundary && enable && !ln_q.written;
        overrun_set  = boundary && enable && !ln_q.fetched;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign tx_line = ln_q.tx_sh;
    assign rx_reg  = ln_q.rx_reg;

endmodule

// File: rtl/tdm_irq_status.sv
module tdm_irq_status #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           boundary,
    input  logic [NCH-1:0] uf_set,
    input  logic [NCH-1:0] of_set,
    input  logic           flags_rd,
    input  logic           ctrl_rd,
    input  logic           ack,
    output logic [NCH-1:0] underrun,
    output logic [NCH-1:0] overrun,
    output logic           pending,
    output logic           missed,
    output logic           irq_status
);

    typedef struct packed {
        logic [NCH-1:0] uf;
        logic [NCH-1:0] of;
        logic           pend;
        logic           miss;
    } stat_s;

    stat_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.uf = (flags_rd ? '0 : st_q.uf) | uf_set;
        st_d.of = (flags_rd ? '0 : st_q.of) | of_set;

        if (ack)      st_d.pend = 1'b0;
        if (boundary) st_d.pend = 1'b1;

        if (ctrl_rd) st_d.miss = 1'b0;
        if (boundary && st_q.pend && !ack) st_d.miss = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign underrun   = st_q.uf;
    assign overrun    = st_q.of;
    assign pending    = st_q.pend;
    assign missed     = st_q.miss;
    assign irq_status = (|st_q.uf) || (|st_q.of) || st_q.miss;

endmodule

// File: rtl/tdm_chbuf.sv
module tdm_chbuf
    import tdm_chbuf_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DW    = 8,
    parameter int SLOTS = 4,
    localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int ADDR_W = $clog2(NCH + 3),
    localparam int RW     = (2 * NCH > DW) ? 2 * NCH : DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    output logic [SW-1:0]     slot_idx,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [RW-1:0]     cpu_rdata,
    output logic [NCH*DW-1:0] line_tx_data,
    input  logic [NCH-1:0]    line_rx_valid,
    input  logic [NCH*DW-1:0] line_rx_data,
    output logic              irq_period,
    output logic              irq_status
);

    typedef struct packed {
        logic [NCH-1:0] enable;
        logic [RW-1:0]  rdata;
    } top_s;

    top_s r_d, r_q;

    logic           boundary;
    logic [NCH-1:0] lane_wr, lane_rd;
    logic [NCH-1:0] uf_set, of_set;
    logic [NCH-1:0] underrun, overrun, enable_vec;
    logic           pending, missed;
    logic           flags_rd, ctrl_rd, ack;
    logic [DW-1:0]  rx_regs [NCH];
    reg_kind_e      kind;

    tdm_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .slot         (slot_idx),
        .boundary     (boundary)
    );

    // address decode
    always_comb begin
        kind     = decode_kind(int'(cpu_addr), NCH);
        flags_rd = cpu_rd && (kind == KIND_FLAGS);
        ctrl_rd  = cpu_rd && (kind == KIND_CTRL);
        ack      = cpu_wr && (kind == KIND_CTRL) && cpu_wdata[CTRL_PEND_BIT];
        for (int c = 0; c < NCH; c++) begin
            lane_wr[c] = cpu_wr && (int'(cpu_addr) == c);
            lane_rd[c] = cpu_rd && (int'(cpu_addr) == c);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        tdm_chan_lane #(.DW(DW)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .boundary     (boundary),
            .enable       (r_q.enable[c]),
            .wr           (lane_wr[c]),
            .wdata        (cpu_wdata),
            .rd           (lane_rd[c]),
            .rx_valid     (line_rx_valid[c]),
            .rx_data      (line_rx_data[c*DW +: DW]),
            .tx_line      (line_tx_data[c*DW +: DW]),
            .rx_reg       (rx_regs[c]),
            .underrun_set (uf_set[c]),
            .overrun_set  (of_set[c])
        );
    end

    tdm_irq_status #(.NCH(NCH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .uf_set     (uf_set),
        .of_set     (of_set),
        .flags_rd   (flags_rd),
        .ctrl_rd    (ctrl_rd),
        .ack        (ack),
        .underrun   (underrun),
        .overrun    (overrun),
        .pending    (pending),
        .missed     (missed),
        .irq_status (irq_status)
    );

    // register file and read path
    always_comb begin
        r_d = r_q;
        if (cpu_wr && kind == KIND_ENABLE) r_d.enable = cpu_wdata[NCH-1:0];
        if (cpu_rd) begin
            r_d.rdata = '0;
            unique case (kind)
                KIND_LANE: begin
                    for (int c = 0; c < NCH; c++)
                        if (int'(cpu_addr) == c) r_d.rdata[DW-1:0] = rx_regs[c];
                end
                KIND_ENABLE: r_d.rdata[NCH-1:0] = r_q.enable;
                KIND_FLAGS:  r_d.rdata[2*NCH-1:0] = {overrun, underrun};
                KIND_CTRL: begin
                    r_d.rdata[CTRL_PEND_BIT] = pending;
                    r_d.rdata[CTRL_MISS_BIT] = missed;
                end
                default: r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign enable_vec = r_q.enable;
    assign cpu_rdata  = r_q.rdata;
    assign irq_period = pending;

endmodule

// File: rtl/tdm_chbuf_checker.sv
module tdm_chbuf_checker #(
    parameter int NCH   = 4,
    parameter int DW    = 8,
    parameter int SLOTS = 4,
    parameter int SW    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe,
    input logic              boundary,
    input logic              ack,
    input logic [SW-1:0]     slot_idx,
    input logic              irq_period,
    input logic              irq_status,
    input logic              missed,
    input logic [NCH-1:0]    underrun,
    input logic [NCH-1:0]    overrun,
    input logic [NCH-1:0]    enable_vec,
    input logic [NCH*DW-1:0] line_tx_data
);

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> (($past(slot_idx) == SW'(SLOTS - 1)) ? (slot_idx == '0)
                                                               : (slot_idx == $past(slot_idx) + 1'b1)));

    assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> irq_period);

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_period) |-> $past(boundary));

    assert_missed_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && irq_period && !ack) |=> missed);

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(line_tx_data));

    assert_flags_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> (((underrun & ~$past(underrun)) | (overrun & ~$past(overrun))) == '0));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> ((((underrun & ~$past(underrun)) | (overrun & ~$past(overrun)))
                       & ~$past(enable_vec)) == '0));

    assert_status_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> $past(boundary));

endmodule

bind tdm_chbuf tdm_chbuf_checker #(
    .NCH(NCH), .DW(DW), .SLOTS(SLOTS), .SW(SW)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .boundary     (boundary),
    .ack          (ack),
    .slot_idx     (slot_idx),
    .irq_period   (irq_period),
    .irq_status   (irq_status),
    .missed       (missed),
    .underrun     (underrun),
    .overrun      (overrun),
    .enable_vec   (enable_vec),
    .line_tx_data (line_tx_data)
);

// File: tb/test_tdm_chbuf.sv
module test_tdm_chbuf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [1:0]  slot_idx;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [31:0] line_tx_data;
    logic [3:0]  line_rx_valid = '0;
    logic [31:0] line_rx_data = '0;
    logic        irq_period;
    logic        irq_status;

    always #10 clk = ~clk;  // 50 MHz

    tdm_chbuf i_tdm_chbuf (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_strobe  (frame_strobe),
        .slot_idx      (slot_idx),
        .cpu_wr        (cpu_wr),
        .cpu_rd        (cpu_rd),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .line_tx_data  (line_tx_data),
        .line_rx_valid (line_rx_valid),
        .line_rx_data  (line_rx_data),
        .irq_period    (irq_period),
        .irq_status    (irq_status)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    // bench model of the requirements
    int       txreg [4];
    int       expline [4];
    int       gath [4];
    int       rxsh [4];
    int       rxreg [4];
    bit [3:0] written, fetched, en, uf, ovr;
    bit       pend, miss;
    int       slot_m;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_read(input int a, output int d);
        @(negedge clk);
        cpu_rd   = 1'b1;
        cpu_addr = 3'(a);
        @(negedge clk);
        cpu_rd = 1'b0;
        d = int'(cpu_rdata);
    endtask

    task automatic cpu_write(input int a, input int v);
        @(negedge clk);
        cpu_wr    = 1'b1;
        cpu_addr  = 3'(a);
        cpu_wdata = 8'(v);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic model_edge();
        uf  |= en & ~written;
        ovr |= en & ~fetched;
        for (int c = 0; c < 4; c++) begin
            expline[c] = txreg[c];
            rxreg[c]   = rxsh[c];
            rxsh[c]    = gath[c];
        end
        written = '0;
        fetched = '0;
        if (pend) miss = 1'b1;
        pend = 1'b1;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        if (slot_m == 3) model_edge();
        slot_m = (slot_m + 1) % 4;
        chk("R2 slot index", int'(slot_idx), slot_m);
        repeat (2) @(negedge clk);
    endtask

    task automatic period_edge();
        for (int s = 0; s < 4; s++) strobe();
    endtask

    task automatic check_line(input string tag);
        for (int c = 0; c < 4; c++)
            chk(tag, int'(line_tx_data[c*8 +: 8]), expline[c]);
    endtask

    initial begin
        int d;
        for (int c = 0; c < 4; c++) begin
            txreg[c] = 0; expline[c] = 0; gath[c] = 0; rxsh[c] = 0; rxreg[c] = 0;
        end
        written = '0; fetched = '0; en = '0; uf = '0; ovr = '0;
        pend = 1'b0; miss = 1'b0; slot_m = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 slot", int'(slot_idx), 0);
        chk("R1 irq_period", int'(irq_period), 0);
        chk("R1 irq_status", int'(irq_status), 0);
        chk("R1 line", int'(line_tx_data), 0);
        for (int a = 0; a < 7; a++) begin
            cpu_read(a, d);
            chk("R1 register", d, 0);
        end
        fetched = 4'hF;  // reset sweep read every lane

        for (int p = 0; p < 16; p++) begin
            int wmask, rmask, en_new;
            if (p > 0) begin
                check_line("R5 line after edge");
                chk("R3 irq_period raised", int'(irq_period), 1);
                chk("R11 irq_status level", int'(irq_status), int'((|uf) || (|ovr) || miss));
                if (p % 4 != 2) begin
                    cpu_read(5, d);
                    chk("R7 R8 R9 R10 flags", d, int'({ovr, uf}));
                    uf = '0; ovr = '0;
                end
                cpu_read(6, d);
                chk("R4 control", d, int'({miss, pend}));
                miss = 1'b0;
                cpu_write(6, 1);
                pend = 1'b0;
                @(negedge clk);
                chk("R3 irq_period after ack", int'(irq_period), 0);
            end

            en_new = (p * 7 + 3) % 16;
            cpu_write(4, en_new);
            en = 4'(en_new);
            cpu_read(4, d);
            chk("R12 enable readback", d, en_new);

            wmask = (p * 13 + 6) % 16;
            rmask = (p * 11 + 5) % 16;
            for (int c = 0; c < 4; c++) begin
                if (wmask[c]) begin
                    int v = (p * 37 + c * 17 + 1) % 256;
                    cpu_write(c, v);
                    txreg[c]   = v;
                    written[c] = 1'b1;
                end
                if (rmask[c]) begin
                    cpu_read(c, d);
                    chk("R6 receive data", d, rxreg[c]);
                    fetched[c] = 1'b1;
                end
            end
            check_line("R5 line held in period");

            // lane 0 gets an early byte that must be overwritten
            @(negedge clk);
            line_rx_valid = 4'b0001;
            line_rx_data  = 32'h0000_00EE;
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                int v = (p * 53 + c * 29 + 7) % 256;
                line_rx_data[c*8 +: 8] = 8'(v);
                gath[c] = v;
            end
            line_rx_valid = 4'hF;
            @(negedge clk);
            line_rx_valid = '0;

            period_edge();
        end

        // R4: edge on top of a pending interrupt
        chk("R3 irq_period before missed edge", int'(irq_period), 1);
        period_edge();
        chk("R11 irq_status with missed", int'(irq_status), 1);
        cpu_read(6, d);
        chk("R4 missed set", d, int'({miss, pend}));
        miss = 1'b0;
        cpu_read(6, d);
        chk("R4 missed cleared by read", d, int'({miss, pend}));
        cpu_read(5, d);
        chk("R10 flags before clear", d, int'({ovr, uf}));
        uf = '0; ovr = '0;
        cpu_read(5, d);
        chk("R10 flags cleared by read", d, 0);
        chk("R11 irq_status low", int'(irq_status), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule